// File: doc/BRIEF.md
# Multicycle State-Machine RISC Core

This block is a compact 32-bit RISC processor core whose control is written as an algorithmic state machine: one state clears the program counter, one fetches, one decodes, and each supported instruction has its own execute state. Every state lasts exactly one clock. A supported instruction therefore costs three cycles, while an unrecognised one costs two: decode sends it straight back to fetch.

Instructions come from a byte-wide instruction ROM. The core presents one word address, and the ROM returns the four bytes starting at that address side by side on a 32-bit bus. The core holds thirty-two 32-bit general registers. It executes five operations: logical left shift, arithmetic right shift, register XOR, add of a sign-extended immediate, and an unconditional jump. A combinational debug read port lets a testbench or monitor observe any register.

Top module: `asm_risc_core`

## Requirements
- R1: While `rst` is high and after it is released, `rom_addr` reads 0 and every register reads 0 through the debug port until the first instruction completes.
- R2: After `rst` falls there is one clear cycle, then fetch and decode cycles. A supported instruction then spends one execute cycle and returns to fetch, so it takes exactly 3 cycles. An unrecognised instruction takes 2 cycles.
- R3: Lane k of `rom_data` (bits 8k+7..8k) carries the ROM byte at `rom_addr`+k, so the byte at +3 is the most significant byte of the instruction word. Fields: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shamt [10:6], funct [5:0], imm [15:0], target [25:0].
- R4: Every instruction that is not a jump leaves the program counter (`rom_addr`) 4 higher than before.
- R5: Opcode 0 with funct 0 writes rd = rt shifted left logically by shamt.
- R6: Opcode 0 with funct 3 writes rd = rt shifted right arithmetically by shamt, filling with the sign bit.
- R7: Opcode 0 with funct 38 writes rd = rs XOR rt.
- R8: Opcode 9 writes rt = rs + sign-extended imm, modulo 2^32, with no trap on overflow.
- R9: Opcode 2 sets the program counter to {bits 31:28 of the incremented PC, target, 2'b00}.
- R10: Register 0 always reads 0; writes addressed to it have no effect.
- R11: Any other opcode, or opcode 0 with any other funct, changes no register and only advances the PC by 4.
- R12: `dbg_data` shows, in the same cycle, the register selected by `dbg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rom_addr | output | 32 | Byte address of the instruction word (the program counter) |
| rom_data | input | 32 | Four ROM bytes from rom_addr upward, byte +k in lane k |
| dbg_addr | input | 5 | Register index for the debug read |
| dbg_data | output | 32 | Contents of the selected register |

## Verification
The bench aims at the following corner cases, each paired with the fault it would expose:
- Arithmetic right shifts of negative values by 31. A logical shift there returns 1 instead of all ones.
- Immediate adds that wrap across 0x7FFFFFFF and 0xFFFFFFFF. A zero-extending adder gives a wrong sum for negative immediates.
- Writes aimed at register 0. If these were not suppressed, a later read of register 0 would return the written value.
- Jumps, plus opcodes and function codes outside the supported set. A wrong jump target or a wrong next-state choice shows up as a program-counter or cycle-count mismatch at the next instruction boundary.

Random programs, with their shift amounts, register indices and immediates drawn at random, are compared instruction by instruction against a reference model inside the bench.

// File: rtl/risc_core_pkg.sv
`timescale 1ns/1ps
package risc_core_pkg;
    localparam int XLEN      = 32;
    localparam int NREGS     = 32;
    localparam int REG_AW    = $clog2(NREGS);
    localparam int BYTE_W    = 8;
    localparam int WORD_BYTES = XLEN / BYTE_W;
    localparam int IMM_W     = 16;
    localparam int TGT_W     = 26;
    localparam int SHAMT_W   = 5;

    localparam logic [5:0] OP_RTYPE = 6'd0;
    localparam logic [5:0] OP_JUMP  = 6'd2;
    localparam logic [5:0] OP_ADDIU = 6'd9;
    localparam logic [5:0] FN_SLL   = 6'd0;
    localparam logic [5:0] FN_SRA   = 6'd3;
    localparam logic [5:0] FN_XOR   = 6'd38;

    typedef enum logic [2:0] {
        S_CLEAR, S_FETCH, S_DECODE, S_SLL, S_SRA, S_XOR, S_ADDIU, S_JUMP
    } core_state_t;

    typedef struct packed {
        logic [5:0]         opcode;
        logic [REG_AW-1:0]  rs;
        logic [REG_AW-1:0]  rt;
        logic [REG_AW-1:0]  rd;
        logic [SHAMT_W-1:0] shamt;
        logic [5:0]         funct;
    } instr_t;

    typedef struct packed {
        logic              wen;
        logic [REG_AW-1:0] waddr;
        logic [XLEN-1:0]   wdata;
    } wb_t;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] imm);
        return {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    endfunction

    function automatic logic [XLEN-1:0] jump_dest(input logic [XLEN-1:0] pc_next,
                                                  input logic [TGT_W-1:0] tgt);
        return {pc_next[XLEN-1:TGT_W+2], tgt, 2'b00};
    endfunction

    function automatic core_state_t decode_next(input instr_t ins);
        core_state_t nxt;
        nxt = S_FETCH;
        unique case (ins.opcode)
            OP_RTYPE: begin
                if (ins.funct == FN_SLL)      nxt = S_SLL;
                else if (ins.funct == FN_SRA) nxt = S_SRA;
                else if (ins.funct == FN_XOR) nxt = S_XOR;
            end
            OP_JUMP:  nxt = S_JUMP;
            OP_ADDIU: nxt = S_ADDIU;
            default:  nxt = S_FETCH;
        endcase
        return nxt;
    endfunction
endpackage

// File: rtl/gpr_file.sv
`timescale 1ns/1ps
module gpr_file
    import risc_core_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wb_t               wb,
    input  logic [REG_AW-1:0] ra_addr,
    output logic [XLEN-1:0]   ra_data,
    input  logic [REG_AW-1:0] rb_addr,
    output logic [XLEN-1:0]   rb_data,
    input  logic [REG_AW-1:0] rc_addr,
    output logic [XLEN-1:0]   rc_data
);
    logic [XLEN-1:0] regs_q [NREGS];

    // R10: index 0 is never written and always reads as zero
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
        end else if (wb.wen && wb.waddr != '0) begin
            regs_q[wb.waddr] <= wb.wdata;
        end
    end

    always_comb begin
        ra_data = (ra_addr == '0) ? '0 : regs_q[ra_addr];
        rb_data = (rb_addr == '0) ? '0 : regs_q[rb_addr];
        rc_data = (rc_addr == '0) ? '0 : regs_q[rc_addr];
    end
endmodule

// File: rtl/exec_unit.sv
`timescale 1ns/1ps
module exec_unit
    import risc_core_pkg::*;
(
    input  core_state_t     state,
    input  logic [XLEN-1:0] ir,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    output wb_t             wb
);
    instr_t ins;
    assign ins = instr_t'(ir);

    always_comb begin
        wb = '0;
        unique case (state)
            S_SLL: begin
                wb.wen   = 1'b1;
                wb.waddr = ins.rd;
                wb.wdata = rt_val << ins.shamt;
            end
            S_SRA: begin
                wb.wen   = 1'b1;
                wb.waddr = ins.rd;
                wb.wdata = $signed(rt_val) >>> ins.shamt;
            end
            S_XOR: begin
                wb.wen   = 1'b1;
                wb.waddr = ins.rd;
                wb.wdata = rs_val ^ rt_val;
            end
            S_ADDIU: begin
                wb.wen   = 1'b1;
                wb.waddr = ins.rt;
                wb.wdata = rs_val + sext_imm(ir[IMM_W-1:0]);
            end
            default: wb = '0;
        endcase
    end
endmodule

// File: rtl/asm_ctrl.sv
`timescale 1ns/1ps
module asm_ctrl
    import risc_core_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [XLEN-1:0] rom_word,
    output core_state_t     state,
    output logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] ir
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_CLEAR;
            pc    <= '0;
            ir    <= '0;
        end else begin
            unique case (state)
                S_CLEAR: begin
                    pc    <= '0;
                    state <= S_FETCH;
                end
                S_FETCH: begin
                    ir    <= rom_word;
                    pc    <= pc + XLEN'(WORD_BYTES);
                    state <= S_DECODE;
                end
                S_DECODE: state <= decode_next(instr_t'(ir));
                S_JUMP: begin
                    pc    <= jump_dest(pc, ir[TGT_W-1:0]);
                    state <= S_FETCH;
                end
                default: state <= S_FETCH;
            endcase
        end
    end

    a_r2_clear_to_fetch: assert property (@(posedge clk) disable iff (rst)
        state == S_CLEAR |=> state == S_FETCH);
    a_r2_fetch_to_decode: assert property (@(posedge clk) disable iff (rst)
        state == S_FETCH |=> state == S_DECODE);
    a_r2_exec_returns: assert property (@(posedge clk) disable iff (rst)
        (state inside {S_SLL, S_SRA, S_XOR, S_ADDIU, S_JUMP}) |=> state == S_FETCH);
    a_r4_pc_step: assert property (@(posedge clk) disable iff (rst)
        state == S_FETCH |=> pc == $past(pc) + 32'd4);
    a_r9_jump_dest: assert property (@(posedge clk) disable iff (rst)
        state == S_JUMP |=> pc == {$past(pc[31:28]), $past(ir[25:0]), 2'b00});
    a_r11_unknown_noop: assert property (@(posedge clk) disable iff (rst)
        (state == S_DECODE && !(ir[31:26] == 6'd2 || ir[31:26] == 6'd9 ||
         (ir[31:26] == 6'd0 && (ir[5:0] == 6'd0 || ir[5:0] == 6'd3 || ir[5:0] == 6'd38))))
        |=> (state == S_FETCH && $stable(pc)));
endmodule

// File: rtl/asm_risc_core.sv
`timescale 1ns/1ps
module asm_risc_core
    import risc_core_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] rom_addr,
    input  logic [31:0] rom_data,
    input  logic [4:0]  dbg_addr,
    output logic [31:0] dbg_data
);
    core_state_t     state;
    logic [XLEN-1:0] pc, ir, rs_val, rt_val;
    wb_t             wb;
    instr_t          ins;

    assign ins      = instr_t'(ir);
    assign rom_addr = pc;

    asm_ctrl u_ctrl (
        .clk(clk), .rst(rst), .rom_word(rom_data),
        .state(state), .pc(pc), .ir(ir)
    );

    gpr_file u_gpr (
        .clk(clk), .rst(rst), .wb(wb),
        .ra_addr(ins.rs), .ra_data(rs_val),
        .rb_addr(ins.rt), .rb_data(rt_val),
        .rc_addr(dbg_addr), .rc_data(dbg_data)
    );

    exec_unit u_exec (
        .state(state), .ir(ir), .rs_val(rs_val), .rt_val(rt_val), .wb(wb)
    );
endmodule

// File: tb/asm_risc_core_tb_top.sv
`timescale 1ns/1ps
module asm_risc_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] rom_addr, rom_data, dbg_data;
    logic [4:0]  dbg_addr = '0;

    logic [7:0]  rom [256];
    logic [31:0] m_r [32];
    logic [31:0] m_pc;
    int          nchk = 0, nfail = 0, cycles = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    assign rom_data = {rom[rom_addr[7:0] + 8'd3], rom[rom_addr[7:0] + 8'd2],
                       rom[rom_addr[7:0] + 8'd1], rom[rom_addr[7:0]]};

    asm_risc_core dut_i (
        .clk(clk), .rst(rst), .rom_addr(rom_addr), .rom_data(rom_data),
        .dbg_addr(dbg_addr), .dbg_data(dbg_data)
    );

    function automatic logic [31:0] enc_r(int fn, int rs, int rt, int rd, int sh);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
    endfunction
    function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] enc_j(int word_idx);
        return {6'd2, 26'(word_idx)};
    endfunction

    task automatic put_word(int idx, logic [31:0] w);
        for (int k = 0; k < 4; k++) rom[(idx*4 + k) % 256] = w[8*k +: 8];
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic read_reg(int a, output logic [31:0] v);
        dbg_addr = 5'(a);
        #0.1;
        v = dbg_data;
    endtask

    task automatic sweep(string tag);
        logic [31:0] v;
        for (int a = 0; a < 32; a++) begin
            read_reg(a, v);
            chk(tag, v, m_r[a]);
        end
    endtask

    // reference model of one instruction
    task automatic iss_step(output string tag, output int ncyc, output int wreg);
        logic [31:0] w, rsv, rtv, res;
        logic [5:0]  op, fn;
        int rs, rt, rd, sh;
        w  = {rom[m_pc[7:0]+8'd3], rom[m_pc[7:0]+8'd2], rom[m_pc[7:0]+8'd1], rom[m_pc[7:0]]};
        op = w[31:26]; fn = w[5:0];
        rs = int'(w[25:21]); rt = int'(w[20:16]); rd = int'(w[15:11]); sh = int'(w[10:6]);
        rsv = m_r[rs]; rtv = m_r[rt];
        m_pc = m_pc + 32'd4;
        ncyc = 3; wreg = -1; res = '0;
        if (op == 6'd0 && fn == 6'd0) begin
            tag = "R5 sll"; wreg = rd; res = rtv << sh;
        end else if (op == 6'd0 && fn == 6'd3) begin
            tag = "R6 sra"; wreg = rd;
            res = rtv;
            for (int i = 0; i < sh; i++) res = {res[31], res[31:1]};
        end else if (op == 6'd0 && fn == 6'd38) begin
            tag = "R7 xor"; wreg = rd; res = rsv ^ rtv;
        end else if (op == 6'd9) begin
            tag = "R8 addiu"; wreg = rt; res = rsv + {{16{w[15]}}, w[15:0]};
        end else if (op == 6'd2) begin
            tag = "R9 jump"; m_pc = {m_pc[31:28], w[25:0], 2'b00};
        end else begin
            tag = "R11 noop"; ncyc = 2;
        end
        if (wreg > 0) m_r[wreg] = res;
        if (wreg == 0) tag = {tag, " R10 r0"};
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        for (int a = 0; a < 32; a++) m_r[a] = '0;
        m_pc = '0;
        chk("R1 pc in reset", rom_addr, 32'd0);
        rst = 1'b0;
        @(negedge clk);   // clear cycle done, core now in fetch
        chk("R1 pc after reset", rom_addr, 32'd0);
        sweep("R1 regs after reset");
    endtask

    task automatic run(int n);
        string tag;
        int ncyc, wreg;
        logic [31:0] v;
        for (int i = 0; i < n; i++) begin
            iss_step(tag, ncyc, wreg);
            repeat (ncyc) @(negedge clk);
            chk({tag, " R2 R3 R4 pc"}, rom_addr, m_pc);
            if (wreg > 0) begin
                read_reg(wreg, v);
                chk({tag, " R12 dbg"}, v, m_r[wreg]);
            end else if (wreg == 0 || ncyc == 2) begin
                sweep(tag);
            end
        end
    endtask

    function automatic logic [31:0] rand_instr();
        int c;
        c = int'($urandom_range(0, 99));
        if (c < 20) return enc_r(0, $urandom_range(0,31), $urandom_range(0,31), $urandom_range(0,31), $urandom_range(0,31));
        if (c < 40) return enc_r(3, $urandom_range(0,31), $urandom_range(0,31), $urandom_range(0,31), $urandom_range(0,31));
        if (c < 58) return enc_r(38, $urandom_range(0,31), $urandom_range(0,31), $urandom_range(0,31), $urandom_range(0,31));
        if (c < 88) return enc_i(9, $urandom_range(0,31), $urandom_range(0,31), $urandom_range(0,65535));
        if (c < 93) return enc_j($urandom_range(0,63));
        if (c < 97) begin
            int op;
            do op = int'($urandom_range(1,63)); while (op == 2 || op == 9);
            return {6'(op), 26'($urandom)};
        end else begin
            int fn;
            do fn = int'($urandom_range(0,63)); while (fn == 0 || fn == 3 || fn == 38);
            return enc_r(fn, $urandom_range(0,31), $urandom_range(0,31), $urandom_range(0,31), $urandom_range(0,31));
        end
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            nfail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 256; i++) rom[i] = '0;
        // directed program
        put_word(0,  enc_i(9, 0, 1, 16'h7FFF));          // r1 = 0x00007FFF
        put_word(1,  enc_i(9, 0, 2, 16'hFFFF));          // r2 = 0xFFFFFFFF (R8 sign ext)
        put_word(2,  enc_r(0, 0, 1, 3, 16));             // r3 = 0x7FFF0000
        put_word(3,  enc_r(0, 0, 2, 5, 31));             // r5 = 0x80000000 (R5 by 31)
        put_word(4,  enc_i(9, 5, 6, 16'hFFFF));          // r6 = 0x7FFFFFFF wrap
        put_word(5,  enc_i(9, 6, 7, 1));                 // r7 = 0x80000000 overflow, no trap
        put_word(6,  enc_r(3, 0, 5, 8, 31));             // r8 = 0xFFFFFFFF (R6 sign fill)
        put_word(7,  enc_r(3, 0, 6, 9, 4));              // r9 = 0x07FFFFFF
        put_word(8,  enc_r(38, 7, 2, 10, 0));            // r10 = 0x7FFFFFFF
        put_word(9,  enc_i(9, 2, 0, 5));                 // write r0 ignored (R10)
        put_word(10, enc_r(0, 0, 7, 0, 1));              // sll into r0 ignored
        put_word(11, {6'h3F, 26'h3FFFFFF});              // unknown opcode (R11)
        put_word(12, enc_r(6'h21, 1, 2, 11, 0));         // unknown funct (R11)
        put_word(13, enc_r(0, 0, 7, 11, 0));             // r11 = r7 << 0
        put_word(14, enc_j(17));                         // skip 15,16 (R9)
        put_word(15, enc_i(9, 0, 12, 16'h1234));
        put_word(16, enc_i(9, 0, 13, 16'h5678));
        put_word(17, enc_r(3, 0, 10, 14, 0));            // r14 = r10 >>> 0
        put_word(18, enc_j(0));
        do_reset();
        run(24);
        sweep("R8 R10 directed final state");
        // random programs
        for (int p = 0; p < 12; p++) begin
            for (int w = 0; w < 64; w++) put_word(w, rand_instr());
            do_reset();
            run(160);
            sweep("R5 R6 R7 R8 random final state");
        end
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule